// File: doc/BRIEF.md
# Freezable Channel Activity Counters

This block keeps four saturating activity counters for a radio MAC: one counts every clock cycle, one counts cycles in which the receive channel reports busy, one counts cycles spent receiving a frame, and one counts cycles spent transmitting a frame. Software derives channel listen time from these counts, for example as total cycles less receive-frame cycles less transmit-frame cycles. For that reason the four counters must advance in step and be captured together.

A control register holds a single hold bit. Setting it stops all four counters on the same clock. Software can then read a coherent snapshot, write each counter back to zero, and clear the hold bit so that counting resumes. Access is through a simple register port with one address, a write strobe and a combinational read.

Register map (3-bit address): 0 is control (bit 0 = hold), 1 is total cycles, 2 is receive busy, 3 is receive frame, 4 is transmit frame. Addresses 5 to 7 are unmapped.

Top module: `chan_activity_counters`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four counters and the hold bit become zero.
- R2: While the hold bit is 0, the total-cycle counter (address 1) increments by one on every clock.
- R3: While the hold bit is 0, the receive-busy (address 2), receive-frame (address 3) and transmit-frame (address 4) counters each increment on a clock at which `busy_i`, `rx_frame_i` or `tx_frame_i` respectively is high, and hold otherwise.
- R4: A write to address 0 with data bit 0 set makes the hold bit 1 from the next clock. From then on, no counter changes except through a write to its own address.
- R5: A write to a counter address loads that counter with `reg_wdata_i` on that clock, so writing zero clears it. The write takes priority over an increment in the same cycle and applies whether or not the hold bit is set.
- R6: A write to address 0 with data bit 0 clear makes the hold bit 0, and counting resumes from the held values.
- R7: A counter that holds all ones stays at all ones when it would otherwise increment.
- R8: `reg_rdata_o` shows the register selected by `reg_addr_i` in the same cycle. Address 0 reads the hold bit in bit 0 and zeros above it. Addresses 5 to 7 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Receive channel busy level |
| rx_frame_i | input | 1 | Receiving-a-frame level |
| tx_frame_i | input | 1 | Transmitting-a-frame level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data (combinational) |

## Verification
The bench builds the block with `CNT_W` = 8 instead of 32. With that width, a few hundred cycles drive the total-cycle and busy counters into saturation, which a 32-bit build could never reach in a simulation. The narrow width also lets the bench load values near the ceiling through the write port. Hold, clear-while-held, release, write-over-increment and unmapped-address cases all run at this width, and a behavioural model is compared against the read port on every clock.

// File: rtl/actcnt_pkg.sv
// Shared constants for the channel activity counter bank.
// Assumes a fixed 3-bit register address space.
package actcnt_pkg;
    localparam int ADDR_W  = 3;
    localparam int NUM_CNT = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 3'd0,
        RA_CYC   = 3'd1,
        RA_BUSY  = 3'd2,
        RA_RXF   = 3'd3,
        RA_TXF   = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/actcnt_counter.sv
// One saturating activity counter.
// Assumes load_i has priority over counting and hold_i stops counting only.
module actcnt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             hold_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Load, count or saturate the activity count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (!hold_i && inc_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

    // R5
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_val_i)));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !load_i) |=> $stable(count_o));

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && (count_o == CNT_MAX)) |=> (count_o == CNT_MAX));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !load_i && inc_i && (count_o != CNT_MAX))
        |=> (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/actcnt_ctrl.sv
// Control register and write decode.
// Holds the freeze bit and turns a register write into per-counter load strobes.
module actcnt_ctrl
    import actcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [CNT_W-1:0]   wdata_i,
    output logic               hold_o,
    output logic [NUM_CNT-1:0] load_o
);
    logic hold_q;

    // Update the freeze bit on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (wr_i && (addr_i == RA_CTRL)) begin
            hold_q <= wdata_i[0];
        end
    end

    // Decode one load strobe per counter address.
    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_load
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(gi + 1);
        assign load_o[gi] = wr_i && (addr_i == MY_ADDR);
    end

    assign hold_o = hold_q;

    // R4
    freeze_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (addr_i == RA_CTRL) && wdata_i[0]) |=> hold_o);

    // R6
    freeze_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (addr_i == RA_CTRL) && !wdata_i[0]) |=> !hold_o);

    // R5
    one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_o));
endmodule

// File: rtl/actcnt_rdmux.sv
// Combinational read selection.
// Assumes unmapped addresses return zero.
module actcnt_rdmux
    import actcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          hold_i,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] counts_i,
    output logic [CNT_W-1:0]              rdata_o
);
    // Pick the register that the address selects.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            RA_CTRL: rdata_o = {{(CNT_W-1){1'b0}}, hold_i};
            RA_CYC:  rdata_o = counts_i[0];
            RA_BUSY: rdata_o = counts_i[1];
            RA_RXF:  rdata_o = counts_i[2];
            RA_TXF:  rdata_o = counts_i[3];
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/chan_activity_counters.sv
// Bank of four freezable, saturating channel activity counters with a
// register port. Counter 0 counts every clock and counters 1 to 3 count
// busy, rx-frame and tx-frame cycles. All share one freeze bit.
module chan_activity_counters
    import actcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              rx_frame_i,
    input  logic              tx_frame_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [CNT_W-1:0]  reg_wdata_i,
    output logic [CNT_W-1:0]  reg_rdata_o
);
    logic                          hold;
    logic [NUM_CNT-1:0]            load;
    logic [NUM_CNT-1:0]            qual;
    logic [NUM_CNT-1:0][CNT_W-1:0] counts;

    assign qual = {tx_frame_i, rx_frame_i, busy_i, 1'b1};

    actcnt_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .hold_o  (hold),
        .load_o  (load)
    );

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        actcnt_counter #(.CNT_W(CNT_W)) cnt_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc_i      (qual[gi]),
            .hold_i     (hold),
            .load_i     (load[gi]),
            .load_val_i (reg_wdata_i),
            .count_o    (counts[gi])
        );
    end

    actcnt_rdmux #(.CNT_W(CNT_W)) rdmux_i (
        .addr_i   (reg_addr_i),
        .hold_i   (hold),
        .counts_i (counts),
        .rdata_o  (reg_rdata_o)
    );

    // R2
    cycle_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !load[0] && (counts[0] != '1)) |=> (counts[0] != $past(counts[0])));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i > RA_TXF) |-> (reg_rdata_o == '0));
endmodule

// File: tb/chan_activity_counters_tb_top.sv
module chan_activity_counters_tb_top;
    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         busy_i = 1'b0, rx_frame_i = 1'b0, tx_frame_i = 1'b0;
    logic         reg_wr_i = 1'b0;
    logic [2:0]   reg_addr_i = 3'd0;
    logic [W-1:0] reg_wdata_i = '0;
    logic [W-1:0] reg_rdata_o;

    int  m_cnt [4];
    bit  m_frz;
    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    chan_activity_counters #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .rx_frame_i(rx_frame_i),
        .tx_frame_i(tx_frame_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
    );

    function automatic int exp_read(input logic [2:0] a);
        if (a == 3'd0) return int'(m_frz);
        if (a <= 3'd4) return m_cnt[a-1];
        return 0;
    endfunction

    // Drive one cycle from a negedge, check the read port, advance the model.
    task automatic step(input logic b, input logic r, input logic t, input logic w,
                        input logic [2:0] a, input int d, input string tag);
        int  exp_v;
        logic q [4];
        busy_i = b; rx_frame_i = r; tx_frame_i = t;
        reg_wr_i = w; reg_addr_i = a; reg_wdata_i = W'(d);
        #1;
        exp_v = exp_read(a);
        n_chk++;
        if (int'(reg_rdata_o) != exp_v) begin
            n_fail++;
            $display("FAIL %s addr=%0d actual=%0d expected=%0d", tag, a, reg_rdata_o, exp_v);
        end
        @(posedge clk);
        q[0] = 1'b1; q[1] = b; q[2] = r; q[3] = t;
        for (int i = 0; i < 4; i++) begin
            if (w && (a == 3'(i + 1))) m_cnt[i] = d & MAX;
            else if (!m_frz && q[i] && m_cnt[i] < MAX) m_cnt[i]++;
        end
        if (w && a == 3'd0) m_frz = d[0];
        @(negedge clk);
    endtask

    task automatic rnd_steps(input int n, input bit incl_ctrl, input string tag);
        for (int k = 0; k < n; k++) begin
            logic [2:0] a;
            a = incl_ctrl ? 3'(k % 5) : 3'(1 + (k % 4));
            step($urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
                 $urandom_range(1, 0) == 1, 1'b0, a, 0, tag);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        m_frz = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: all registers start at zero
        step(0, 0, 0, 0, 3'd1, 0, "R1");
        step(0, 0, 0, 0, 3'd0, 0, "R1");
        step(0, 0, 0, 0, 3'd2, 0, "R1");
        // R2 R3: free running with varied input patterns
        rnd_steps(60, 1'b0, "R2/R3");
        for (int k = 0; k < 8; k++) step(1, 0, 1, 0, 3'(1 + (k % 4)), 0, "R3");
        // R4: freeze, then snapshot must not move
        step(1, 1, 1, 1, 3'd0, 1, "R4");
        rnd_steps(20, 1'b1, "R4");
        // R5: clear while frozen, with inputs active
        for (int i = 1; i <= 4; i++) step(1, 1, 1, 1, 3'(i), 0, "R5");
        for (int i = 0; i <= 4; i++) step(1, 1, 1, 0, 3'(i), 0, "R5");
        step(1, 1, 1, 1, 3'd2, 'h55, "R5");
        step(1, 1, 1, 0, 3'd2, 0, "R5");
        // R6: release and resume
        step(0, 0, 0, 1, 3'd0, 0, "R6");
        rnd_steps(30, 1'b1, "R6");
        // R5: write wins over increment while running
        step(0, 1, 0, 1, 3'd3, 'h10, "R5");
        step(0, 1, 0, 0, 3'd3, 0, "R5");
        step(0, 0, 1, 1, 3'd4, MAX, "R5");
        step(0, 0, 1, 0, 3'd4, 0, "R5");
        // R7: saturation of cycle and busy counters
        step(1, 0, 0, 1, 3'd2, MAX - 3, "R7");
        for (int k = 0; k < 300; k++) step(1, 0, 0, 0, 3'(1 + (k % 2)), 0, "R7");
        step(0, 0, 1, 0, 3'd4, 0, "R7");
        // R8: unmapped addresses read zero and ignore writes
        for (int i = 5; i <= 7; i++) step(1, 1, 1, 1, 3'(i), 'hA5, "R8");
        for (int i = 5; i <= 7; i++) step(0, 0, 0, 0, 3'(i), 0, "R8");
        step(0, 0, 0, 1, 3'd0, 'hFF, "R8");
        step(0, 0, 0, 0, 3'd0, 0, "R8");
        for (int i = 1; i <= 4; i++) step(0, 1, 0, 0, 3'(i), 0, "R8");
        step(0, 0, 0, 1, 3'd0, 'hFE, "R8");
        step(0, 0, 0, 0, 3'd0, 0, "R8");
        rnd_steps(10, 1'b1, "R8");
        // R1: reset in mid-run returns everything to zero
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        m_frz = 1'b0;
        step(0, 0, 0, 0, 3'd1, 0, "R1");
        step(0, 0, 0, 0, 3'd3, 0, "R1");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule